// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block registers the address and command lines that a memory module fans out to its DRAM devices. Two static configuration inputs choose its topology. In the wide topology it registers 25 data lanes, one output per lane. In the paired topology it registers 14 lanes and drives each registered bit onto two output copies. In that topology the device is set up either as the first or the second buffer of a pair, and that choice decides which 14 of the 25 input lanes it takes.

Two active-low chip-select inputs gate the data registers. When neither rank is selected, the data outputs keep their value and do not toggle. The clock-enable, termination-enable and chip-select lines are registered on every clock and are never gated. An active-low reset clears every output at once. Its release is synchronised to the clock, so an idle bus stays quiet while the block comes out of reset.

Top module: `cmd_fanout_reg`

## Requirements
- R1: While `rst_n` is low, every output is 0. This holds from the moment `rst_n` falls, without waiting for a clock edge.
- R2: In the wide topology (`cfg_c0`=0, `cfg_c1`=0), a rising edge with a rank selected loads `din` into `q_a`. The value appears one clock after it is sampled.
- R3: In the paired-first topology (`cfg_c0`=0, `cfg_c1`=1), `q_a[13:0]` and `q_b[13:0]` both take `din[13:0]`, and `q_a[24:14]` is 0.
- R4: In the paired-second topology (`cfg_c0`=1, `cfg_c1`=1), `q_a[13:0]` and `q_b[13:0]` both take `din[24:11]`, and `q_a[24:14]` is 0.
- R5: The reserved code (`cfg_c0`=1, `cfg_c1`=0) behaves exactly like the wide topology.
- R6: When `cs0_n` and `cs1_n` are both 1 at a rising edge, `q_a` and `q_b` keep their previous values. This holds whatever `din` and the configuration inputs do.
- R7: `cke_q`, `odt_q`, `cs0_q_n` and `cs1_q_n` always equal `cke_in`, `odt_in`, `cs0_n` and `cs1_n` from one clock earlier. Chip-select has no effect on them.
- R8: In the wide and reserved topologies, `q_b` is 0.
- R9: If `rst_n` rises while all inputs are 0, every output stays 0 on every following cycle until an input changes.
- R10: A single asserted chip-select (either `cs0_n` or `cs1_n` low) is enough to load the data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| cfg_c0 | input | 1 | Configuration input 0 |
| cfg_c1 | input | 1 | Configuration input 1 |
| cs0_n | input | 1 | Chip-select, rank 0, active low |
| cs1_n | input | 1 | Chip-select, rank 1, active low |
| cke_in | input | 1 | Clock-enable command line |
| odt_in | input | 1 | Termination-enable command line |
| din | input | 25 | Address and command data lanes |
| q_a | output | 25 | Registered data, first copy (all lanes in wide topology) |
| q_b | output | 14 | Registered data, second copy (paired topologies only) |
| cke_q | output | 1 | Registered clock-enable |
| odt_q | output | 1 | Registered termination-enable |
| cs0_q_n | output | 1 | Registered chip-select, rank 0 |
| cs1_q_n | output | 1 | Registered chip-select, rank 1 |

## Verification
The hardest case to reach from the ports is a hold that survives a change on the other inputs. Both chip-selects are deasserted, and then the data and the configuration change while the control lines keep moving. The stimulus first loads a known pattern in the wide topology. It then deselects both ranks, drives a different pattern and switches to the paired-second topology. After that it checks that `q_a` and `q_b` still show the old pattern while the control outputs follow their inputs. A second hard case is a reset that arrives between clock edges. The bench lowers `rst_n` in the middle of a cycle after loading all-ones data and checks the outputs before the next rising edge.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

  // Topology selected by the two configuration inputs.
  typedef enum logic [1:0] {
    TOPO_WIDE   = 2'd0,
    TOPO_PAIR_A = 2'd1,
    TOPO_PAIR_B = 2'd2
  } topo_e;

  // The reserved code {c0,c1} = 2'b10 falls back to the wide topology.
  function automatic topo_e decode_topo(input logic c0, input logic c1);
    topo_e t;
    case ({c0, c1})
      2'b01:   t = TOPO_PAIR_A;
      2'b11:   t = TOPO_PAIR_B;
      default: t = TOPO_WIDE;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/cmdbuf_rst_sync.sv
module cmdbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_nxt;

  always_comb begin
    stg_nxt = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_nxt;
    end
  end

  assign rst_sync_n = stg_q[STAGES-1];

  // R1: the internal reset follows an external assertion without waiting for a clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_sync_low_R1: assert (rst_sync_n == 1'b0);
    end
  end

endmodule

// File: rtl/cmdbuf_lane_map.sv
module cmdbuf_lane_map
  import cmdbuf_pkg::*;
#(
  parameter int DATA_W = 25,
  parameter int PAIR_W = 14
) (
  input  topo_e             topo,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] nxt_a,
  output logic [PAIR_W-1:0] nxt_b
);

  localparam int B_LO = DATA_W - PAIR_W;

  logic              is_wide;
  logic              is_b;
  logic [PAIR_W-1:0] pair_bits;

  assign is_wide = (topo == TOPO_WIDE);
  assign is_b    = (topo == TOPO_PAIR_B);

  // The second buffer of a pair owns the upper lanes and the first owns the lower lanes.
  for (genvar j = 0; j < PAIR_W; j++) begin : g_pair
    assign pair_bits[j] = is_b ? din[B_LO + j] : din[j];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i < PAIR_W) begin : g_lo
      assign nxt_a[i] = is_wide ? din[i] : pair_bits[i];
    end else begin : g_hi
      assign nxt_a[i] = is_wide & din[i];
    end
  end

  assign nxt_b = is_wide ? '0 : pair_bits;

endmodule

// File: rtl/cmdbuf_data_bank.sv
module cmdbuf_data_bank #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         ld_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (ld_en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= '0;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

  // R6: no load while no rank is selected
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ld_en) |=> $stable(q));

  // R1: the bank is clear while reset is held
  always @(posedge clk) begin
    if (!rst_ni) begin
      assert_bank_clear_R1: assert (q == '0);
    end
  end

endmodule

// File: rtl/cmdbuf_ctrl_reg.sv
module cmdbuf_ctrl_reg #(
  parameter int CS_W = 2
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            cke_in,
  input  logic            odt_in,
  input  logic [CS_W-1:0] cs_n_in,
  output logic            cke_q,
  output logic            odt_q,
  output logic [CS_W-1:0] cs_n_q
);

  localparam int CW = CS_W + 2;

  logic [CW-1:0] ctl_r;
  logic [CW-1:0] ctl_nxt;

  // Ungated: the control lines load on every clock.
  always_comb begin
    ctl_nxt = {cke_in, odt_in, cs_n_in};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_r <= '0;
    end else begin
      ctl_r <= ctl_nxt;
    end
  end

  assign cke_q  = ctl_r[CW-1];
  assign odt_q  = ctl_r[CW-2];
  assign cs_n_q = ctl_r[CS_W-1:0];

  // R7: the control outputs follow their inputs with one clock of latency
  assert_ctrl_follow_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(rst_ni) |=> (cke_q == $past(cke_in)) && (odt_q == $past(odt_in))
                      && (cs_n_q == $past(cs_n_in)));

endmodule

// File: rtl/cmd_fanout_reg.sv
module cmd_fanout_reg
  import cmdbuf_pkg::*;
#(
  parameter int DATA_W     = 25,
  parameter int PAIR_W     = 14,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_c0,
  input  logic              cfg_c1,
  input  logic              cs0_n,
  input  logic              cs1_n,
  input  logic              cke_in,
  input  logic              odt_in,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q_a,
  output logic [PAIR_W-1:0] q_b,
  output logic              cke_q,
  output logic              odt_q,
  output logic              cs0_q_n,
  output logic              cs1_q_n
);

  localparam int B_LO = DATA_W - PAIR_W;
  localparam int CS_W = 2;

  logic              rst_sync_n;
  topo_e             topo;
  logic              ld_en;
  logic [DATA_W-1:0] nxt_a;
  logic [PAIR_W-1:0] nxt_b;
  logic [CS_W-1:0]   cs_n_bus;
  logic [CS_W-1:0]   cs_n_q;

  assign topo     = decode_topo(cfg_c0, cfg_c1);
  assign cs_n_bus = {cs1_n, cs0_n};
  assign ld_en    = ~(&cs_n_bus);

  cmdbuf_rst_sync #(.STAGES(SYNC_STAGE)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmdbuf_lane_map #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_lane_map (
    .topo  (topo),
    .din   (din),
    .nxt_a (nxt_a),
    .nxt_b (nxt_b)
  );

  cmdbuf_data_bank #(.W(DATA_W)) u_bank_a (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .ld_en  (ld_en),
    .d      (nxt_a),
    .q      (q_a)
  );

  cmdbuf_data_bank #(.W(PAIR_W)) u_bank_b (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .ld_en  (ld_en),
    .d      (nxt_b),
    .q      (q_b)
  );

  cmdbuf_ctrl_reg #(.CS_W(CS_W)) u_ctrl (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .cke_in  (cke_in),
    .odt_in  (odt_in),
    .cs_n_in (cs_n_bus),
    .cke_q   (cke_q),
    .odt_q   (odt_q),
    .cs_n_q  (cs_n_q)
  );

  assign cs0_q_n = cs_n_q[0];
  assign cs1_q_n = cs_n_q[1];

  // Port-level checks: each one relates din at one edge to q at the next edge.
  logic sel;
  assign sel = !(cs0_n && cs1_n);

  // R1: every output is low while reset is held
  assert_reset_clear_R1: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (q_a == '0) && (q_b == '0) && !cke_q && !odt_q
                                  && !cs0_q_n && !cs1_q_n);

  // R2: the wide topology is a one-to-one register
  assert_wide_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && sel && !cfg_c0 && !cfg_c1) |=> (q_a == $past(din)));

  // R3: the first buffer of a pair copies the low lanes twice
  assert_pair_a_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && sel && !cfg_c0 && cfg_c1) |=>
      (q_a[PAIR_W-1:0] == $past(din[PAIR_W-1:0])) && (q_b == $past(din[PAIR_W-1:0]))
      && (q_a[DATA_W-1:PAIR_W] == '0));

  // R4: the second buffer of a pair copies the high lanes twice
  assert_pair_b_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && sel && cfg_c0 && cfg_c1) |=>
      (q_a[PAIR_W-1:0] == $past(din[DATA_W-1:B_LO])) && (q_b == $past(din[DATA_W-1:B_LO]))
      && (q_a[DATA_W-1:PAIR_W] == '0));

  // R5: the reserved code behaves like the wide topology
  assert_reserved_wide_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && sel && cfg_c0 && !cfg_c1) |=> (q_a == $past(din)) && (q_b == '0));

  // R8: the second copy stays idle in the single-copy topologies
  assert_dup_idle_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && sel && !cfg_c1) |=> (q_b == '0));

  // R10: one asserted chip-select alone loads the data registers
  assert_one_cs_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && (cs0_n ^ cs1_n) && !cfg_c0 && !cfg_c1) |=> (q_a == $past(din)));

endmodule

// File: tb/cmd_fanout_reg_tb_top.sv
module cmd_fanout_reg_tb_top;

  localparam int DW = 25;
  localparam int PW = 14;

  logic          clk;
  logic          rst_n;
  logic          cfg_c0, cfg_c1, cs0_n, cs1_n, cke_in, odt_in;
  logic [DW-1:0] din;
  logic [DW-1:0] q_a;
  logic [PW-1:0] q_b;
  logic          cke_q, odt_q, cs0_q_n, cs1_q_n;

  int n_chk = 0;
  int n_err = 0;

  cmd_fanout_reg dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_c0(cfg_c0), .cfg_c1(cfg_c1),
    .cs0_n(cs0_n), .cs1_n(cs1_n), .cke_in(cke_in), .odt_in(odt_in),
    .din(din), .q_a(q_a), .q_b(q_b), .cke_q(cke_q), .odt_q(odt_q),
    .cs0_q_n(cs0_q_n), .cs1_q_n(cs1_q_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic logic [DW-1:0] m_qa(input logic c0, input logic c1, input logic [DW-1:0] d);
    if (!c1) return d;
    if (c0)  return {{(DW-PW){1'b0}}, d[DW-1:DW-PW]};
    return {{(DW-PW){1'b0}}, d[PW-1:0]};
  endfunction

  function automatic logic [PW-1:0] m_qb(input logic c0, input logic c1, input logic [DW-1:0] d);
    if (!c1) return '0;
    if (c0)  return d[DW-1:DW-PW];
    return d[PW-1:0];
  endfunction

  // Drive on a falling edge; the result is visible at the next falling edge.
  task automatic step(input logic c0, input logic c1, input logic s0, input logic s1,
                      input logic ck, input logic od, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_c0 = c0; cfg_c1 = c1; cs0_n = s0; cs1_n = s1; cke_in = ck; odt_in = od; din = d;
    @(negedge clk);
  endtask

  task automatic chk_all_zero(input string tag);
    chk(tag, {q_a, q_b, cke_q, odt_q, cs0_q_n, cs1_q_n}, 64'd0);
  endtask

  task automatic chk_data(input string tag, input logic c0, input logic c1, input logic [DW-1:0] d);
    chk({tag, " q_a"}, q_a, m_qa(c0, c1, d));
    chk({tag, " q_b"}, q_b, m_qb(c0, c1, d));
  endtask

  task automatic t_reset_state();
    chk_all_zero("R1 reset held");
  endtask

  task automatic t_release_quiet();
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk_all_zero("R9 quiet release");
    end
  endtask

  task automatic t_wide();
    logic [DW-1:0] pat [3];
    pat[0] = 25'h1FFFFFF; pat[1] = 25'h0AAAAAA; pat[2] = 25'h0123456;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, k[0], ~k[0], pat[k]);
      chk_data("R2 R8 wide", 1'b0, 1'b0, pat[k]);
    end
  endtask

  task automatic t_pair_a();
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 25'h1FFC000);
    chk_data("R3 pair first high-only", 1'b0, 1'b1, 25'h1FFC000);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 25'h1ABCDEF);
    chk_data("R3 pair first", 1'b0, 1'b1, 25'h1ABCDEF);
  endtask

  task automatic t_pair_b();
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 25'h00007FF);
    chk_data("R4 pair second low-only", 1'b1, 1'b1, 25'h00007FF);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 25'h1555555);
    chk_data("R4 pair second", 1'b1, 1'b1, 25'h1555555);
  endtask

  task automatic t_reserved();
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 25'h1E0F0F1);
    chk_data("R5 reserved code", 1'b0, 1'b0, 25'h1E0F0F1);
  endtask

  task automatic t_cs_hold();
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 25'h13579BD);
    chk_data("R6 preload", 1'b0, 1'b0, 25'h13579BD);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 25'h0ECA864);
    chk_data("R6 hold across mode change", 1'b0, 1'b0, 25'h13579BD);
    chk("R7 ctrl while deselected", {cke_q, odt_q, cs1_q_n, cs0_q_n}, 64'hF);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 25'h1FFFFFF);
    chk_data("R6 hold second cycle", 1'b0, 1'b0, 25'h13579BD);
    chk("R7 ctrl follows", {cke_q, odt_q, cs1_q_n, cs0_q_n}, 64'h7);
  endtask

  task automatic t_single_cs();
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 25'h0F0F0F0);
    chk_data("R10 cs0 only", 1'b0, 1'b0, 25'h0F0F0F0);
    chk("R7 cs mirror a", {cs1_q_n, cs0_q_n}, 64'h2);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 25'h10F0F0F);
    chk_data("R10 cs1 only", 1'b0, 1'b0, 25'h10F0F0F);
    chk("R7 cs mirror b", {cs1_q_n, cs0_q_n}, 64'h1);
  endtask

  task automatic t_async_reset();
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 25'h1FFFFFF);
    chk_data("R1 preload", 1'b0, 1'b1, 25'h1FFFFFF);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk_all_zero("R1 async clear before edge");
    cfg_c0 = 0; cfg_c1 = 0; cs0_n = 0; cs1_n = 0; cke_in = 0; odt_in = 0; din = '0;
    repeat (2) @(negedge clk);
    chk_all_zero("R1 reset held again");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all_zero("R9 second release");
  endtask

  initial begin
    rst_n = 1'b1;
    cfg_c0 = 0; cfg_c1 = 0; cs0_n = 0; cs1_n = 0; cke_in = 0; odt_in = 0; din = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_release_quiet();
    t_wide();
    t_pair_a();
    t_pair_b();
    t_reserved();
    t_cs_hold();
    t_single_cs();
    t_async_reset();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule